// File: doc/BRIEF.md
# Debug Core Register Access Sequencer

This block reads or writes one processor core register from outside the processor. Core registers are not in the memory map. They are reached through three memory-mapped debug registers: a data register at 0xE000EDF8, a selector register at 0xE000EDF4 and a halting control/status register at 0xE000EDF0. The block reaches those registers through a memory access port. It turns one front-side request into a chain of serial-wire-debug register transactions and hands each one to a separate transaction engine.

Each memory word access follows one of two patterns. A write is an AP write of the address to the transfer-address register, then an AP write of the data to the data-read/write register. A read is an AP write to the transfer-address register, then a posted AP read of the data-read/write register whose returned value is discarded, then a DP read of the read-buffer register, which carries the real word. After the selector is written, the sequencer polls the ready flag in the status register. It gives up with a timeout after a programmable number of polls. Any transaction that comes back with a bad acknowledge or a parity error ends the operation at once.

Top module: `core_reg_seq`

## Requirements
- R1: While an operation is in progress, `op_ready` is 0 and `op_valid` is ignored. No transaction is issued and no register is touched for a request that is offered while busy.
- R2: A write first writes `op_wdata` to the data register (0xE000EDF8). It then writes the selector register (0xE000EDF4) with the register number in bits 6:0, bit 16 set to 1 and all other bits 0. It then polls the status register. With d not-ready polls, it issues 7+2d transactions.
- R3: A read writes the selector (bit 16 = 0, register number in bits 6:0), polls the status register, and then reads the data register. It returns that word on `rd_data`. With d not-ready polls, it issues 8+2d transactions.
- R4: Every memory access uses this encoding. The transfer-address register is an AP access at address 0x4. The data-read/write register is an AP access at 0xC. The read-buffer register is a DP access at 0xC. A memory read takes its data only from the read-buffer response and never from the posted AP read. All addresses written to the transfer-address register have bits 1:0 equal to 0.
- R5: A status poll is an AP read at 0xC followed by a DP read of the read buffer. The register counts as ready when bit 16 of the read-buffer word is 1. The data register is never read before a poll has returned ready.
- R6: If `poll_limit` polls all return not-ready, the operation ends with `result` = 3 (timeout). A limit of 0 acts as 1. A write then takes 5+2L transactions and a read 3+2L.
- R7: A response with `rsp_ack` other than 3'b001 ends the operation with no further transaction. `result` is 1 and `fault_ack` is the received acknowledge.
- R8: A response with `rsp_perr` = 1 and a good acknowledge ends the operation with no further transaction and `result` = 2.
- R9: `done` is high for exactly one cycle per accepted operation. `result` is 0 on success, and `rd_data` is valid with `done` after a successful read.
- R10: While `txn_valid` is high and no response has arrived, all request fields stay stable.
- R11: After reset, `op_ready` = 1, `done` = 0 and `txn_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation request |
| op_ready | output | 1 | Idle, an operation can be accepted |
| op_write | input | 1 | 1 = write core register, 0 = read |
| op_regnum | input | 7 | Core register number |
| op_wdata | input | 32 | Data for a write |
| poll_limit | input | CNT_W | Maximum number of status polls |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 32 | Read result |
| result | output | 2 | 0 ok, 1 ack fault, 2 parity, 3 timeout |
| fault_ack | output | 3 | Acknowledge of the failing transaction |
| txn_valid | output | 1 | Transaction request to engine |
| txn_ap | output | 1 | 1 = AP, 0 = DP |
| txn_addr | output | 4 | Register byte address (bits 3:2 significant) |
| txn_rnw | output | 1 | 1 = read, 0 = write |
| txn_wdata | output | 32 | Write data |
| rsp_valid | input | 1 | One-cycle response from engine |
| rsp_ack | input | 3 | Acknowledge, 3'b001 = OK |
| rsp_perr | input | 1 | Read parity error |
| rsp_rdata | input | 32 | Read data |

## Verification
Writes and reads are run with no ready delay and with several polls before ready. This shows whether the poll loop re-enters correctly and whether the data register is kept back until ready. Timeouts are run with a normal limit and with a zero limit, which separates the bound and its clamp. Faults are injected early in a write, in the middle of a poll and at the final buffer read, with WAIT, FAULT and parity codes. This shows that the abort is immediate and that each failure gets the right result code. A request offered while busy, and register numbers 0 and 127, cover acceptance and the edges of the selector encoding.

// File: rtl/crs_pkg.sv
package crs_pkg;

    localparam int DATA_W = 32;
    localparam int REG_W  = 7;
    localparam int ACK_W  = 3;

    localparam logic [3:0] ADDR_TAR = 4'h4;
    localparam logic [3:0] ADDR_DRW = 4'hC;
    localparam logic [3:0] ADDR_BUF = 4'hC;

    localparam logic [DATA_W-1:0] MEM_DATA = 32'hE000_EDF8;
    localparam logic [DATA_W-1:0] MEM_SEL  = 32'hE000_EDF4;
    localparam logic [DATA_W-1:0] MEM_STAT = 32'hE000_EDF0;

    localparam int RDY_BIT = 16;
    localparam int DIR_BIT = 16;
    localparam logic [ACK_W-1:0] ACK_OK = 3'b001;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_TAR_DAT,
        ST_DRW_WR,
        ST_TAR_SEL,
        ST_DRW_SEL,
        ST_TAR_STA,
        ST_POLL_AP,
        ST_POLL_DP,
        ST_RD_AP,
        ST_RD_DP
    } step_e;

    typedef enum logic [1:0] {
        RES_OK      = 2'd0,
        RES_ACK     = 2'd1,
        RES_PARITY  = 2'd2,
        RES_TIMEOUT = 2'd3
    } result_e;

    typedef struct packed {
        logic              ap;
        logic [3:0]        addr;
        logic              rnw;
        logic [DATA_W-1:0] data;
    } txn_t;

    function automatic logic [DATA_W-1:0] sel_word(input logic wr, input logic [REG_W-1:0] rn);
        logic [DATA_W-1:0] w;
        w = '0;
        w[REG_W-1:0] = rn;
        w[DIR_BIT]   = wr;
        return w;
    endfunction

endpackage

// File: rtl/crs_req_map.sv
module crs_req_map
    import crs_pkg::*;
(
    input  step_e                step,
    input  logic                 wr,
    input  logic [REG_W-1:0]     regnum,
    input  logic [DATA_W-1:0]    wdata,
    output logic                 valid,
    output txn_t                 req
);
    always_comb begin
        valid = (step != ST_IDLE);
        req   = '{ap: 1'b1, addr: ADDR_DRW, rnw: 1'b1, data: '0};
        unique case (step)
            ST_TAR_DAT: req = '{ap: 1'b1, addr: ADDR_TAR, rnw: 1'b0, data: MEM_DATA};
            ST_DRW_WR:  req = '{ap: 1'b1, addr: ADDR_DRW, rnw: 1'b0, data: wdata};
            ST_TAR_SEL: req = '{ap: 1'b1, addr: ADDR_TAR, rnw: 1'b0, data: MEM_SEL};
            ST_DRW_SEL: req = '{ap: 1'b1, addr: ADDR_DRW, rnw: 1'b0, data: sel_word(wr, regnum)};
            ST_TAR_STA: req = '{ap: 1'b1, addr: ADDR_TAR, rnw: 1'b0, data: MEM_STAT};
            ST_POLL_AP,
            ST_RD_AP:   req = '{ap: 1'b1, addr: ADDR_DRW, rnw: 1'b1, data: '0};
            ST_POLL_DP,
            ST_RD_DP:   req = '{ap: 1'b0, addr: ADDR_BUF, rnw: 1'b1, data: '0};
            default:    req = '{ap: 1'b1, addr: ADDR_DRW, rnw: 1'b1, data: '0};
        endcase
    end
endmodule

// File: rtl/crs_poll_ctr.sv
module crs_poll_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] limit,
    input  logic             bump,
    output logic             last
);
    logic [CNT_W-1:0] lim_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lim_q <= CNT_W'(1);
            cnt_q <= '0;
        end else if (start) begin
            lim_q <= (limit == '0) ? CNT_W'(1) : limit;
            cnt_q <= '0;
        end else if (bump) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = ({1'b0, cnt_q} + 1'b1) >= {1'b0, lim_q};

    AST_POLL_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q < lim_q); // R6
endmodule

// File: rtl/crs_fsm.sv
module crs_fsm
    import crs_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               op_valid,
    input  logic               op_write,
    input  logic [REG_W-1:0]   op_regnum,
    input  logic [DATA_W-1:0]  op_wdata,
    input  logic               rsp_valid,
    input  logic [ACK_W-1:0]   rsp_ack,
    input  logic               rsp_perr,
    input  logic [DATA_W-1:0]  rsp_rdata,
    input  logic               poll_last,
    output step_e              step,
    output logic               start,
    output logic               bump,
    output logic               wr_q,
    output logic [REG_W-1:0]   regnum_q,
    output logic [DATA_W-1:0]  wdata_q,
    output logic               done,
    output logic [DATA_W-1:0]  rd_data,
    output result_e            result,
    output logic [ACK_W-1:0]   fault_ack
);
    logic fail;
    logic ready_seen;

    assign start      = (step == ST_IDLE) && op_valid;
    assign fail       = rsp_valid && ((rsp_ack != ACK_OK) || rsp_perr);
    assign ready_seen = rsp_rdata[RDY_BIT];
    assign bump       = rsp_valid && !fail && (step == ST_POLL_DP) && !ready_seen && !poll_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            step      <= ST_IDLE;
            wr_q      <= 1'b0;
            regnum_q  <= '0;
            wdata_q   <= '0;
            done      <= 1'b0;
            rd_data   <= '0;
            result    <= RES_OK;
            fault_ack <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                wr_q      <= op_write;
                regnum_q  <= op_regnum;
                wdata_q   <= op_wdata;
                fault_ack <= '0;
                step      <= op_write ? ST_TAR_DAT : ST_TAR_SEL;
            end else if (step != ST_IDLE && rsp_valid) begin
                if (fail) begin
                    step      <= ST_IDLE;
                    done      <= 1'b1;
                    result    <= (rsp_ack != ACK_OK) ? RES_ACK : RES_PARITY;
                    fault_ack <= (rsp_ack != ACK_OK) ? rsp_ack : '0;
                end else begin
                    unique case (step)
                        ST_TAR_DAT: step <= wr_q ? ST_DRW_WR : ST_RD_AP;
                        ST_DRW_WR:  step <= ST_TAR_SEL;
                        ST_TAR_SEL: step <= ST_DRW_SEL;
                        ST_DRW_SEL: step <= ST_TAR_STA;
                        ST_TAR_STA: step <= ST_POLL_AP;
                        ST_POLL_AP: step <= ST_POLL_DP;
                        ST_POLL_DP: begin
                            if (ready_seen) begin
                                if (wr_q) begin
                                    step   <= ST_IDLE;
                                    done   <= 1'b1;
                                    result <= RES_OK;
                                end else begin
                                    step <= ST_TAR_DAT;
                                end
                            end else if (poll_last) begin
                                step   <= ST_IDLE;
                                done   <= 1'b1;
                                result <= RES_TIMEOUT;
                            end else begin
                                step <= ST_POLL_AP;
                            end
                        end
                        ST_RD_AP:   step <= ST_RD_DP;
                        ST_RD_DP: begin
                            rd_data <= rsp_rdata;
                            step    <= ST_IDLE;
                            done    <= 1'b1;
                            result  <= RES_OK;
                        end
                        default:    step <= ST_IDLE;
                    endcase
                end
            end
        end
    end

    AST_DATA_AFTER_READY: assert property (@(posedge clk) disable iff (rst)
        (step == ST_TAR_DAT && $past(step) == ST_POLL_DP) |-> $past(rsp_rdata[RDY_BIT])); // R5

    AST_ABORT_NOW: assert property (@(posedge clk) disable iff (rst)
        (step != ST_IDLE && rsp_valid && rsp_ack != ACK_OK) |=> (done && step == ST_IDLE && result == RES_ACK)); // R7
endmodule

// File: rtl/core_reg_seq.sv
module core_reg_seq
    import crs_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 op_valid,
    output logic                 op_ready,
    input  logic                 op_write,
    input  logic [REG_W-1:0]     op_regnum,
    input  logic [DATA_W-1:0]    op_wdata,
    input  logic [CNT_W-1:0]     poll_limit,
    output logic                 done,
    output logic [DATA_W-1:0]    rd_data,
    output logic [1:0]           result,
    output logic [ACK_W-1:0]     fault_ack,
    output logic                 txn_valid,
    output logic                 txn_ap,
    output logic [3:0]           txn_addr,
    output logic                 txn_rnw,
    output logic [DATA_W-1:0]    txn_wdata,
    input  logic                 rsp_valid,
    input  logic [ACK_W-1:0]     rsp_ack,
    input  logic                 rsp_perr,
    input  logic [DATA_W-1:0]    rsp_rdata
);
    step_e             step;
    logic              start;
    logic              bump;
    logic              poll_last;
    logic              wr_q;
    logic [REG_W-1:0]  regnum_q;
    logic [DATA_W-1:0] wdata_q;
    result_e           res_e;
    txn_t              req;

    crs_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .op_valid  (op_valid),
        .op_write  (op_write),
        .op_regnum (op_regnum),
        .op_wdata  (op_wdata),
        .rsp_valid (rsp_valid),
        .rsp_ack   (rsp_ack),
        .rsp_perr  (rsp_perr),
        .rsp_rdata (rsp_rdata),
        .poll_last (poll_last),
        .step      (step),
        .start     (start),
        .bump      (bump),
        .wr_q      (wr_q),
        .regnum_q  (regnum_q),
        .wdata_q   (wdata_q),
        .done      (done),
        .rd_data   (rd_data),
        .result    (res_e),
        .fault_ack (fault_ack)
    );

    crs_poll_ctr #(.CNT_W(CNT_W)) u_poll (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .limit (poll_limit),
        .bump  (bump),
        .last  (poll_last)
    );

    crs_req_map u_map (
        .step   (step),
        .wr     (wr_q),
        .regnum (regnum_q),
        .wdata  (wdata_q),
        .valid  (txn_valid),
        .req    (req)
    );

    assign op_ready  = (step == ST_IDLE);
    assign result    = res_e;
    assign txn_ap    = req.ap;
    assign txn_addr  = req.addr;
    assign txn_rnw   = req.rnw;
    assign txn_wdata = req.data;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (txn_valid && !rsp_valid) |=> (txn_valid && $stable(txn_ap) && $stable(txn_addr)
                                       && $stable(txn_rnw) && $stable(txn_wdata))); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        op_ready |-> !txn_valid); // R1

    AST_DONE_ONCE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9
endmodule

// File: tb/tb_core_reg_seq.sv
module tb_core_reg_seq;
    localparam int CNT_W = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic        op_ready;
    logic        op_write = 1'b0;
    logic [6:0]  op_regnum = '0;
    logic [31:0] op_wdata = '0;
    logic [CNT_W-1:0] poll_limit = '0;
    logic        done;
    logic [31:0] rd_data;
    logic [1:0]  result;
    logic [2:0]  fault_ack;
    logic        txn_valid, txn_ap, txn_rnw;
    logic [3:0]  txn_addr;
    logic [31:0] txn_wdata;
    logic        rsp_valid = 1'b0;
    logic [2:0]  rsp_ack = 3'b001;
    logic        rsp_perr = 1'b0;
    logic [31:0] rsp_rdata = '0;

    always #2.5 clk = ~clk;

    core_reg_seq #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_ready(op_ready),
        .op_write(op_write), .op_regnum(op_regnum), .op_wdata(op_wdata),
        .poll_limit(poll_limit), .done(done), .rd_data(rd_data),
        .result(result), .fault_ack(fault_ack), .txn_valid(txn_valid),
        .txn_ap(txn_ap), .txn_addr(txn_addr), .txn_rnw(txn_rnw),
        .txn_wdata(txn_wdata), .rsp_valid(rsp_valid), .rsp_ack(rsp_ack),
        .rsp_perr(rsp_perr), .rsp_rdata(rsp_rdata)
    );

    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // target model state
    logic [31:0] core [128];
    logic [31:0] tar, dcrdr, rdbuff;
    bit          rdy = 1'b1;
    int          rdy_left = 0;
    int          delay = 0;
    int          tx_cnt = 0;
    int          viol = 0;
    int          fault_at = -1;
    logic [2:0]  fault_code = 3'b001;
    int          par_at = -1;

    task automatic serve(output logic [2:0] ack, output logic perr, output logic [31:0] rd);
        int idx;
        idx = tx_cnt;
        tx_cnt++;
        ack = 3'b001;
        perr = 1'b0;
        rd = 32'hBAD0_0000 | idx;
        if (idx == fault_at) begin
            ack = fault_code;
            return;
        end
        if (idx == par_at) perr = 1'b1;
        if (txn_ap && !txn_rnw && txn_addr == 4'h4) begin
            tar = txn_wdata;
            if (tar[1:0] != 2'b00) viol++;
        end else if (txn_ap && !txn_rnw && txn_addr == 4'hC) begin
            if (tar == 32'hE000_EDF8) dcrdr = txn_wdata;
            else if (tar == 32'hE000_EDF4) begin
                if (txn_wdata[31:17] != 0 || txn_wdata[15:7] != 0) viol++;
                if (txn_wdata[16]) core[txn_wdata[6:0]] = dcrdr;
                else dcrdr = core[txn_wdata[6:0]];
                rdy = 1'b0;
                rdy_left = delay;
            end else viol++;
        end else if (txn_ap && txn_rnw && txn_addr == 4'hC) begin
            if (tar == 32'hE000_EDF0) begin
                if (rdy_left == 0) rdy = 1'b1;
                else rdy_left--;
                rdbuff = 32'h0003_0003;
                rdbuff[16] = rdy;
            end else if (tar == 32'hE000_EDF8) begin
                if (!rdy) viol++;
                rdbuff = dcrdr;
            end else viol++;
        end else if (!txn_ap && txn_rnw && txn_addr == 4'hC) begin
            rd = rdbuff;
        end else viol++;
    endtask

    int lat = 0;
    initial begin
        logic [2:0]  a;
        logic        p;
        logic [31:0] d;
        forever begin
            @(negedge clk);
            if (txn_valid && !rst) begin
                serve(a, p, d);
                repeat (lat) @(negedge clk);
                lat = (lat + 1) % 3;
                rsp_ack = a; rsp_perr = p; rsp_rdata = d;
                rsp_valid = 1'b1;
                @(negedge clk);
                rsp_valid = 1'b0;
                rsp_ack = 3'b001; rsp_perr = 1'b0; rsp_rdata = 32'h5555_AAAA;
            end
        end
    end

    typedef struct {
        logic [1:0]  res;
        logic [31:0] data;
        bit          chk_data;
        logic [2:0]  ack;
        string       tag;
    } exp_t;
    exp_t sb[$];

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && done) begin
                exp_t e;
                if (sb.size() == 0) begin
                    check(1'b0, "R9 unexpected done", 32'd1, 32'd0);
                end else begin
                    e = sb.pop_front();
                    check(result == e.res, {e.tag, " result"}, 32'(result), 32'(e.res));
                    check(fault_ack == e.ack, {e.tag, " R7 fault_ack"}, 32'(fault_ack), 32'(e.ack));
                    if (e.chk_data) check(rd_data == e.data, {e.tag, " R3 R4 rd_data"}, rd_data, e.data);
                end
                @(negedge clk);
                check(done == 1'b0, "R9 done width", 32'(done), 32'd0);
            end
        end
    end

    task automatic run_op(input bit wr, input logic [6:0] rn, input logic [31:0] wd,
                          input int lim, input int dly, input int f_at, input logic [2:0] f_code,
                          input int p_at, input logic [1:0] e_res, input logic [31:0] e_data,
                          input logic [2:0] e_ack, input int e_txns, input string tag);
        exp_t e;
        while (!op_ready) @(negedge clk);
        tx_cnt = 0; viol = 0; delay = dly;
        fault_at = f_at; fault_code = f_code; par_at = p_at;
        e.res = e_res; e.data = e_data; e.chk_data = (!wr && e_res == 2'd0);
        e.ack = e_ack; e.tag = tag;
        sb.push_back(e);
        op_write = wr; op_regnum = rn; op_wdata = wd; poll_limit = CNT_W'(lim);
        op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        while (sb.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        check(tx_cnt == e_txns, {tag, " transaction count"}, 32'(tx_cnt), 32'(e_txns));
        check(viol == 0, {tag, " R4 R5 protocol violations"}, 32'(viol), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd1, 32'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 128; i++) core[i] = 32'hC0DE_0000 + i;
        repeat (4) @(negedge clk);
        // R11 reset state
        check(op_ready == 1'b1, "R11 op_ready", 32'(op_ready), 32'd1);
        check(done == 1'b0, "R11 done", 32'(done), 32'd0);
        check(txn_valid == 1'b0, "R11 txn_valid", 32'(txn_valid), 32'd0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R2 write, ready at first poll
        run_op(1, 7'd7, 32'h1234_5678, 8, 0, -1, 3'b001, -1, 2'd0, 0, 3'd0, 7, "R2 write r7");
        check(core[7] == 32'h1234_5678, "R2 core r7", core[7], 32'h1234_5678);
        // R3 read back
        run_op(0, 7'd7, 0, 8, 0, -1, 3'b001, -1, 2'd0, 32'h1234_5678, 3'd0, 8, "R3 read r7");
        // R5 write with delayed ready
        run_op(1, 7'd3, 32'hA5A5_0F0F, 10, 3, -1, 3'b001, -1, 2'd0, 0, 3'd0, 13, "R5 write r3 delay3");
        check(core[3] == 32'hA5A5_0F0F, "R2 core r3", core[3], 32'hA5A5_0F0F);
        run_op(0, 7'd3, 0, 10, 2, -1, 3'b001, -1, 2'd0, 32'hA5A5_0F0F, 3'd0, 12, "R5 read r3 delay2");
        // boundary register numbers
        run_op(1, 7'd127, 32'hFFFF_FFFF, 4, 0, -1, 3'b001, -1, 2'd0, 0, 3'd0, 7, "R2 write r127");
        check(core[127] == 32'hFFFF_FFFF, "R2 core r127", core[127], 32'hFFFF_FFFF);
        run_op(0, 7'd0, 0, 4, 1, -1, 3'b001, -1, 2'd0, 32'hC0DE_0000, 3'd0, 10, "R3 read r0");
        // R6 timeout
        run_op(0, 7'd5, 0, 4, 9, -1, 3'b001, -1, 2'd3, 0, 3'd0, 11, "R6 read timeout L4");
        run_op(1, 7'd2, 32'h0BAD_F00D, 0, 1, -1, 3'b001, -1, 2'd3, 0, 3'd0, 7, "R6 write timeout L0");
        // R7 ack faults
        run_op(1, 7'd4, 32'h1111_2222, 8, 0, 1, 3'b010, -1, 2'd1, 0, 3'b010, 2, "R7 write WAIT");
        check(core[4] == 32'hC0DE_0004, "R7 core r4 untouched", core[4], 32'hC0DE_0004);
        run_op(0, 7'd6, 0, 8, 0, 4, 3'b100, -1, 2'd1, 0, 3'b100, 5, "R7 read FAULT in poll");
        // R8 parity on final buffer read
        run_op(0, 7'd6, 0, 8, 0, -1, 3'b001, 7, 2'd2, 0, 3'd0, 8, "R8 read parity");

        // R1 busy: second request ignored
        begin
            exp_t e;
            while (!op_ready) @(negedge clk);
            tx_cnt = 0; viol = 0; delay = 2; fault_at = -1; par_at = -1;
            e.res = 2'd0; e.data = 0; e.chk_data = 0; e.ack = 3'd0; e.tag = "R1 write r9";
            sb.push_back(e);
            op_write = 1; op_regnum = 7'd9; op_wdata = 32'h9999_0000; poll_limit = 16'd8;
            op_valid = 1'b1;
            @(negedge clk);
            op_write = 1; op_regnum = 7'd10; op_wdata = 32'hDEAD_0010;
            repeat (3) begin
                check(op_ready == 1'b0, "R1 op_ready busy", 32'(op_ready), 32'd0);
                @(negedge clk);
            end
            op_valid = 1'b0;
            while (sb.size() != 0) @(negedge clk);
            repeat (4) @(negedge clk);
            check(tx_cnt == 11, "R1 transaction count", 32'(tx_cnt), 32'd11);
            check(core[9] == 32'h9999_0000, "R1 core r9", core[9], 32'h9999_0000);
            check(core[10] == 32'hC0DE_000A, "R1 core r10 untouched", core[10], 32'hC0DE_000A);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule